// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block is the bus interface of a small 8-bit processor. A core hands it one request at a time: a 16-bit address, a memory or I/O space flag, a direction, and write data. The controller runs one machine cycle on an external bus where the low address byte and the data byte share the same 8 lines. It drives the dedicated upper address lines, the shared lines with their output enable, an address latch strobe, a space status line, and active-low read and write strobes. External logic captures the low address byte on the falling edge of the latch strobe.

A cycle runs through T1, T2, zero or more wait states and T3. A write adds one trailing state in which the data stays on the bus after the write strobe has risen. The ready input is sampled at the end of T2 and at the end of each wait state. Each low sample stretches the strobe by one clock. Read data is captured at the clock edge that ends T3, which is also where the read strobe rises. The core is told that the cycle has finished by a one-cycle done pulse.

An external master takes the bus with hold. The request is honoured only while the controller is idle, and it wins over a pending core request. The controller first spends one cycle with every output enable low. After that it raises the acknowledge, and it holds the acknowledge until hold is removed. Tristate pads are modelled as output-enable signals.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `req_ready_o` is high exactly when the controller is idle and `hold_i` is low. A request is taken when `req_valid_i` and `req_ready_o` are both high at a clock edge. T1 follows in the next cycle, and the request inputs are ignored after they have been taken.
- R2: In T1, `ale_o` is high for exactly one cycle, with both strobes high. In T1, `ad_o` carries address bits 7:0 with `ad_oe_o` high, and `addr_hi_o` carries address bits 15:8. `addr_hi_o` and `io_m_o` hold their values across the falling edge of `ale_o` and for the rest of the cycle.
- R3: `io_m_o` is 0 for a memory access and 1 for an I/O access. For I/O, the port number (address bits 7:0) appears on `ad_o` in T1 and is repeated on `addr_hi_o`.
- R4: On a read, `rd_n_o` is low from T2 through T3 (including any wait states), `wr_n_o` stays high, and `ad_oe_o` is low.
- R5: On a write, `wr_n_o` is low from T2 through T3, `rd_n_o` stays high, and `ad_o` carries the write data with `ad_oe_o` high. One further cycle keeps the data driven with `wr_n_o` high. After that cycle the lines are released.
- R6: `ready_i` is sampled at the end of T2 and at the end of each wait state. Each low sample adds exactly one cycle with the strobe held active.
- R7: On a read, the value on `ad_i` during T3 is loaded into `rdata_o` at the edge that ends T3. `rdata_o` then keeps that value until the next read completes. `done_o` is high for exactly one cycle, in the cycle after the last bus state of each access.
- R8: `hold_i` is acted on only while the controller is idle, and it has priority over a request. In the first cycle after it is taken, `addr_hi_oe_o`, `ad_oe_o` and `ctl_oe_o` are low and `hlda_o` is still low. From the next cycle on, `hlda_o` is high for as long as `hold_i` stays high. If `hold_i` is dropped during that first cycle, `hlda_o` never rises.
- R9: When `hold_i` is low at the end of a cycle with `hlda_o` high, the next cycle is idle, with `hlda_o` low and the address and control enables high again.
- R10: During and right after reset the controller is idle: `ale_o`=0, `rd_n_o`=`wr_n_o`=1, `ad_oe_o`=0, `hlda_o`=0, `done_o`=0, `rdata_o`=0, `addr_hi_o`=0 and `io_m_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_addr_i | input | 16 | Request address |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle pulse when the access has finished |
| rdata_o | output | 8 | Last read data |
| addr_hi_o | output | 8 | Upper address lines |
| addr_hi_oe_o | output | 1 | Enable for the upper address lines |
| ad_o | output | 8 | Shared address/data lines, outbound value |
| ad_i | input | 8 | Shared address/data lines, inbound value |
| ad_oe_o | output | 1 | Enable for the shared lines |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | Space status: 1 = I/O, 0 = memory |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ctl_oe_o | output | 1 | Enable for the status and strobe outputs |
| ready_i | input | 1 | Low requests wait states |
| hold_i | input | 1 | External master bus request |
| hlda_o | output | 1 | Bus grant acknowledge |

## Verification
Ready is dropped for zero, one, two and three samples, and the bench compares every cycle of the stretched strobe. A design that samples ready in T1 or T3, or that adds more or fewer than one wait per sample, shifts the strobe or the done pulse by a cycle. Read data on `ad_i` is valid only during T3 and holds its inverse elsewhere, so a capture one edge early or late loads the wrong byte. Hold is raised in the middle of a write, raised with a request waiting, and raised as a one-cycle blip. A controller that grants mid-transfer, lets a waiting request win, raises the acknowledge in the same cycle as the float, or acknowledges a blip shows a mismatch on the enables or on `hlda_o`. I/O cycles check that the port number is repeated on the upper lines, and writes check the extra cycle of data after the strobe rises.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1    = 3'd1,
    ST_T2    = 3'd2,
    ST_TW    = 3'd3,
    ST_T3    = 3'd4,
    ST_T4    = 3'd5,
    ST_FLOAT = 3'd6,
    ST_HLDA  = 3'd7
  } bus_st_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    cur_write_i,
  input  logic    ready_i,
  input  logic    hold_i,
  output bus_st_e state_o,
  output logic    req_ready_o,
  output logic    accept_o,
  output logic    finish_o
);
  bus_st_e st_q, st_d;

  assign req_ready_o = (st_q == ST_IDLE) && !hold_i;
  assign accept_o    = req_ready_o && req_valid_i;
  // last bus state of the access: T3 on reads, trailing T4 on writes
  assign finish_o    = ((st_q == ST_T3) && !cur_write_i) || (st_q == ST_T4);
  assign state_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold_i)           st_d = ST_FLOAT;
        else if (req_valid_i) st_d = ST_T1;
      end
      ST_T1:    st_d = ST_T2;
      ST_T2,
      ST_TW:    st_d = ready_i ? ST_T3 : ST_TW;
      ST_T3:    st_d = cur_write_i ? ST_T4 : ST_IDLE;
      ST_T4:    st_d = ST_IDLE;
      ST_FLOAT: st_d = hold_i ? ST_HLDA : ST_IDLE;
      ST_HLDA:  st_d = hold_i ? ST_HLDA : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R8: the bus is floated only from a cycle boundary
  p_float_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLOAT) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  bus_st_e                    state_i,
  input  logic                       accept_i,
  input  logic                       finish_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic                       req_io_i,
  input  logic                       req_write_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  input  logic [DATA_W-1:0]          ad_i,
  output logic                       cur_write_o,
  output logic                       done_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [ADDR_W-DATA_W-1:0]   addr_hi_o,
  output logic                       addr_hi_oe_o,
  output logic [DATA_W-1:0]          ad_o,
  output logic                       ad_oe_o,
  output logic                       ale_o,
  output logic                       io_m_o,
  output logic                       rd_n_o,
  output logic                       wr_n_o,
  output logic                       ctl_oe_o,
  output logic                       hlda_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic              io_q, wr_q, done_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [HI_W-1:0]   io_hi;
  logic              strobe_ph, floated;

  // port number repeated across the upper lines for I/O cycles
  for (genvar g = 0; g < HI_W; g++) begin : g_io_hi
    assign io_hi[g] = addr_q[g % DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        io_q    <= req_io_i;
        wr_q    <= req_write_i;
        wdata_q <= req_wdata_i;
      end
      // edge ending T3 is the rising edge of the read strobe
      if (state_i == ST_T3 && !wr_q) rdata_q <= ad_i;
      done_q <= finish_i;
    end
  end

  assign strobe_ph    = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
  assign floated      = (state_i == ST_FLOAT) || (state_i == ST_HLDA);

  assign cur_write_o  = wr_q;
  assign done_o       = done_q;
  assign rdata_o      = rdata_q;
  assign ale_o        = (state_i == ST_T1);
  assign addr_hi_o    = io_q ? io_hi : addr_q[ADDR_W-1:DATA_W];
  assign addr_hi_oe_o = !floated;
  assign ctl_oe_o     = !floated;
  assign io_m_o       = io_q;
  assign ad_o         = (state_i == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign ad_oe_o      = (state_i == ST_T1) || (wr_q && (strobe_ph || state_i == ST_T4));
  assign rd_n_o       = !(strobe_ph && !wr_q);
  assign wr_n_o       = !(strobe_ph && wr_q);
  assign hlda_o       = (state_i == ST_HLDA);

  // R5: write data still driven and unchanged when the write strobe rises
  p_wr_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_n_o) |-> (ad_oe_o && $stable(ad_o)));
  // R4: shared lines released while the read strobe is low
  p_rd_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic                     req_io_i,
  input  logic                     req_write_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     addr_hi_oe_o,
  output logic [DATA_W-1:0]        ad_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic                     ad_oe_o,
  output logic                     ale_o,
  output logic                     io_m_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     ctl_oe_o,
  input  logic                     ready_i,
  input  logic                     hold_i,
  output logic                     hlda_o
);
  bus_st_e st;
  logic    accept, finish, cur_write;

  mbus_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .cur_write_i (cur_write),
    .ready_i     (ready_i),
    .hold_i      (hold_i),
    .state_o     (st),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .finish_o    (finish)
  );

  mbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (st),
    .accept_i     (accept),
    .finish_i     (finish),
    .req_addr_i   (req_addr_i),
    .req_io_i     (req_io_i),
    .req_write_i  (req_write_i),
    .req_wdata_i  (req_wdata_i),
    .ad_i         (ad_i),
    .cur_write_o  (cur_write),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .addr_hi_o    (addr_hi_o),
    .addr_hi_oe_o (addr_hi_oe_o),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .ale_o        (ale_o),
    .io_m_o       (io_m_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .ctl_oe_o     (ctl_oe_o),
    .hlda_o       (hlda_o)
  );

  p_ale_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  p_ale_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && ad_oe_o));
  p_addr_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> ($stable(addr_hi_o) && $stable(io_m_o)));
  p_io_dup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && io_m_o) |-> (addr_hi_o[0] == ad_o[0]));
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  p_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_T2 || st == ST_TW) && !ready_i) |=> (st == ST_TW && (!rd_n_o || !wr_n_o)));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rd_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(!rd_n_o)) |-> (rdata_o == $past(ad_i)));
  p_hlda_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !addr_hi_oe_o && !ctl_oe_o));
  p_hlda_after_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(!ctl_oe_o && !addr_hi_oe_o));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) |-> (ctl_oe_o && addr_hi_oe_o && !ale_o));
endmodule

// File: tb/sim_mux_bus_ctrl.sv
`timescale 1ns/1ps
module sim_mux_bus_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = 8'h00;
  logic        ready_in = 1'b1, hold_in = 1'b0;
  logic        req_ready, done, addr_hi_oe, ad_oe, ale, io_m, rd_n, wr_n, ctl_oe, hlda;
  logic [7:0]  rdata, addr_hi, ad_out;

  mux_bus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_io_i(req_io), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .addr_hi_o(addr_hi), .addr_hi_oe_o(addr_hi_oe),
    .ad_o(ad_out), .ad_i(ad_in), .ad_oe_o(ad_oe), .ale_o(ale), .io_m_o(io_m),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .ctl_oe_o(ctl_oe), .ready_i(ready_in),
    .hold_i(hold_in), .hlda_o(hlda)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference state kept by the bench
  logic [7:0] m_hi = 8'h00, m_rdata = 8'h00;
  bit m_io = 1'b0, m_done = 1'b0;

  task automatic ck(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs already driven for this cycle; compare, then advance to next negedge
  task automatic cyc(string tag, bit e_rdy, bit e_ale, bit e_adoe, logic [7:0] e_ad,
                     bit e_hioe, bit e_ctloe, bit e_rdn, bit e_wrn, bit e_hlda);
    #1;
    ck(tag, "req_ready", req_ready, e_rdy);
    ck(tag, "ale", ale, e_ale);
    ck(tag, "ad_oe", ad_oe, e_adoe);
    if (e_adoe) ck(tag, "ad", ad_out, e_ad);
    ck(tag, "addr_hi_oe", addr_hi_oe, e_hioe);
    if (e_hioe) ck(tag, "addr_hi", addr_hi, m_hi);
    ck(tag, "ctl_oe", ctl_oe, e_ctloe);
    if (e_ctloe) ck(tag, "io_m", io_m, m_io);
    ck(tag, "rd_n", rd_n, e_rdn);
    ck(tag, "wr_n", wr_n, e_wrn);
    ck(tag, "hlda", hlda, e_hlda);
    ck("R7", "done", done, m_done);
    ck("R7", "rdata", rdata, m_rdata);
    m_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_cyc(string tag);
    cyc(tag, !hold_in, 0, 0, 8'h00, 1, 1, 1, 1, 0);
  endtask

  task automatic xfer(logic [15:0] a, bit io, bit wr, logic [7:0] wd, logic [7:0] rv,
                      int nw, bit hold_mid);
    req_valid = 1; req_addr = a; req_io = io; req_write = wr; req_wdata = wd;
    ready_in = 1;
    cyc("R1", 1, 0, 0, 8'h00, 1, 1, 1, 1, 0);
    // R1: request inputs changed after acceptance must have no effect
    req_valid = 0; req_addr = ~a; req_io = !io; req_write = !wr; req_wdata = ~wd;
    if (hold_mid) hold_in = 1;
    m_hi = io ? a[7:0] : a[15:8];
    m_io = io;
    cyc(io ? "R3" : "R2", 0, 1, 1, a[7:0], 1, 1, 1, 1, 0);
    ready_in = (nw == 0);
    cyc(wr ? "R5" : "R4", 0, 0, wr, wd, 1, 1, wr, !wr, 0);
    for (int k = 0; k < nw; k++) begin
      ready_in = (k == nw - 1);
      cyc("R6", 0, 0, wr, wd, 1, 1, wr, !wr, 0);
    end
    ready_in = 1;
    ad_in = rv;
    cyc(wr ? "R5" : "R4", 0, 0, wr, wd, 1, 1, wr, !wr, 0);
    ad_in = ~rv;
    if (!wr) m_rdata = rv;
    else cyc("R5", 0, 0, 1, wd, 1, 1, 1, 1, 0);
    m_done = 1;
  endtask

  task automatic hold_seq(int nack, bit with_req);
    if (with_req) begin
      req_valid = 1; req_addr = 16'h0BAD; req_io = 0; req_write = 0;
    end
    hold_in = 1;
    cyc("R8", 0, 0, 0, 8'h00, 1, 1, 1, 1, 0);
    cyc("R8", 0, 0, 0, 8'h00, 0, 0, 1, 1, 0);
    for (int k = 0; k < nack - 1; k++) cyc("R8", 0, 0, 0, 8'h00, 0, 0, 1, 1, 1);
    hold_in = 0;
    cyc("R9", 0, 0, 0, 8'h00, 0, 0, 1, 1, 1);
    if (!with_req) idle_cyc("R9");
  endtask

  task automatic hold_blip();
    hold_in = 1;
    cyc("R8", 0, 0, 0, 8'h00, 1, 1, 1, 1, 0);
    hold_in = 0;
    cyc("R8", 0, 0, 0, 8'h00, 0, 0, 1, 1, 0);
    idle_cyc("R9");
    idle_cyc("R8");
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    ad_in = 8'hFF;
    @(negedge clk);
    cyc("R10", 1, 0, 0, 8'h00, 1, 1, 1, 1, 0);
    cyc("R10", 1, 0, 0, 8'h00, 1, 1, 1, 1, 0);
    rst_ni = 1;
    idle_cyc("R10");
    xfer(16'h12A4, 0, 0, 8'h00, 8'h5A, 0, 0);
    xfer(16'h3456, 0, 1, 8'hC3, 8'h11, 0, 0);
    xfer(16'h997E, 1, 0, 8'h00, 8'h81, 2, 0);
    idle_cyc("R7");
    idle_cyc("R1");
    xfer(16'h5540, 1, 1, 8'h0F, 8'h22, 3, 1);
    hold_seq(3, 0);
    hold_blip();
    hold_seq(2, 1);
    xfer(16'hFFFF, 0, 0, 8'h00, 8'hEE, 1, 0);
    xfer(16'h8001, 0, 1, 8'h77, 8'h33, 0, 0);
    idle_cyc("R7");
    idle_cyc("R1");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule